// File: doc/BRIEF.md
# 64-bit Dual-Address-Cycle Target Address Decoder

This block sits on a 64-bit PCI bus as a passive observer of address phases. When a master starts a transaction by pulling `framen` low, the block captures the address and bus command. If the low command nibble marks a dual address cycle, it waits one more clock and takes the upper 32 address bits from the second address phase. Otherwise it treats the transaction as a single address cycle with the upper half zero.

The assembled 64-bit address is compared with a 64-bit base register that spans two 32-bit BARs. Only the bits selected by a size mask take part in the comparison. On a match the block claims the transaction with slow-decode timing by driving `devseln` low. It also drives `ack64n` low in the same clock if the master asked for a 64-bit data path, and raises both bits of the per-BAR hit vector. The claim is held until the bus returns to idle and the surrounding logic pulses an end-of-transfer strobe. Data-phase handshaking is handled elsewhere.

Top module: `dac_target_decode`

## Requirements
- R1: While `rst_n` is low, `devseln` and `ack64n` are 1, `barHit` is 0, and `latAddr` and `latCmd` are 0. This holds even when reset arrives during a claim.
- R2: If `cben[3:0]` is 4'b1101 in the first address phase (the clock in which `framen` is first sampled low), the cycle is a dual address cycle. `latAddr[31:0]` takes `ad[31:0]` and `latCmd` takes `cben[7:4]` from that phase. `latAddr[63:32]` takes `ad[63:32]` from the next clock.
- R3: For any other first-phase code on `cben[3:0]`, `latAddr` is `ad[31:0]` zero-extended, whatever `ad[63:32]` holds. `latCmd` takes `cben[3:0]`.
- R4: The address matches when `(latAddr ^ barBase) & barMask` is zero. Address bits where `barMask` is 0 have no effect on the decision.
- R5: Count edge 1 as the edge where `framen` is first sampled low. For a dual address cycle, `devseln` stays high after edges 1 and 2 and changes after edge 3. For a single address cycle, it stays high after edge 1 and changes after edge 2.
- R6: `ack64n` goes low in the same clock as `devseln` only if `req64n` was low at edge 1. Otherwise it stays high.
- R7: On a claim, both bits of `barHit` go to 1 in the same clock as `devseln`. At all other times `barHit` is 0.
- R8: A claim is held while `framen` is low, even if `xferDone` is high. It is also held while `framen` is high and `xferDone` is low. After the edge where `framen` and `xferDone` are both high, `devseln` and `ack64n` return to 1 and `barHit` returns to 0.
- R9: On a miss, `devseln`, `ack64n` and `barHit` stay inactive for the whole transaction. No new capture starts until `framen` has been sampled high.
- R10: `latAddr` and `latCmd` keep their values after a transaction until the first address phase of the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| framen | input | 1 | Active-low transaction frame |
| req64n | input | 1 | Active-low 64-bit transfer request |
| ad | input | 64 | Address/data bus |
| cben | input | 8 | Command / byte-enable bus |
| barBase | input | 64 | Base address of the 64-bit BAR pair |
| barMask | input | 64 | Size mask, 1 = compared bit |
| xferDone | input | 1 | End-of-transaction strobe from data-phase logic |
| devseln | output | 1 | Active-low device select (claim) |
| ack64n | output | 1 | Active-low 64-bit transfer acknowledge |
| barHit | output | 2 | Per-BAR hit vector |
| latAddr | output | 64 | Latched transaction address |
| latCmd | output | 4 | Latched bus command |

## Verification
The embedded assertions check several rules on every clock:
- `devseln` never falls during an address-phase state.
- `ack64n` is never low without `devseln`.
- The hit bits are always equal and follow the claim.
- A claim is held while `framen` is low and dropped right after the release condition.
- A miss never asserts anything.
- The upper address half is zero after a single-cycle capture, and the lower half is untouched by the second phase.

Only the bench scenarios can show that the exact address and command values are latched, and at which edge the claim appears. They also show the aperture edges of the mask comparison, re-arming after a miss, and the effect of reset in the middle of a claim.

// File: rtl/dacdec_pkg.sv
package dacdec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR2,
    ST_DECODE,
    ST_CLAIM,
    ST_BUSY
  } decState_t;

  typedef struct packed {
    logic capFirst;
    logic capSecond;
  } dpStrobe_t;

endpackage

// File: rtl/dacdec_dpath.sv
module dacdec_dpath
  import dacdec_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CMD_W = 4,
  parameter logic [CMD_W-1:0] DAC_CMD = 4'b1101
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dpStrobe_t            stb,
  input  logic [ADDR_W-1:0]    ad,
  input  logic [2*CMD_W-1:0]   cben,
  input  logic [ADDR_W-1:0]    barBase,
  input  logic [ADDR_W-1:0]    barMask,
  output logic [ADDR_W-1:0]    latAddr,
  output logic [CMD_W-1:0]     latCmd,
  output logic                 addrMatch
);

  localparam int HALF_W = ADDR_W / 2;

  logic [HALF_W-1:0] addrLo;
  logic [HALF_W-1:0] addrHi;
  logic [CMD_W-1:0]  cmdQ;
  logic              firstIsDac;
  logic [1:0]        halfMatch;

  assign firstIsDac = (cben[CMD_W-1:0] == DAC_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrLo <= '0;
      addrHi <= '0;
      cmdQ   <= '0;
    end else begin
      if (stb.capFirst) begin
        addrLo <= ad[HALF_W-1:0];
        addrHi <= '0;
        cmdQ   <= firstIsDac ? cben[2*CMD_W-1:CMD_W] : cben[CMD_W-1:0];
      end
      if (stb.capSecond) begin
        addrHi <= ad[ADDR_W-1:HALF_W];
      end
    end
  end

  // Masked compare, split per address half
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] addrHalf;
    assign addrHalf = (h == 0) ? addrLo : addrHi;
    assign halfMatch[h] =
      ((addrHalf ^ barBase[h*HALF_W +: HALF_W]) & barMask[h*HALF_W +: HALF_W]) == '0;
  end

  assign addrMatch = &halfMatch;
  assign latAddr   = {addrHi, addrLo};
  assign latCmd    = cmdQ;

  // R3: single address cycle leaves the upper half zero
  assert_sac_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.capFirst && !firstIsDac) |=> (latAddr[ADDR_W-1:HALF_W] == '0));

  // R2: the second phase never disturbs the lower half
  assert_second_keeps_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.capSecond |=> $stable(latAddr[HALF_W-1:0]));

  // R10: address and command change only on a capture strobe
  assert_hold_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.capFirst && !stb.capSecond) |=> ($stable(latAddr) && $stable(latCmd)));

endmodule

// File: rtl/dacdec_ctrl.sv
module dacdec_ctrl
  import dacdec_pkg::*;
#(
  parameter int CMD_W = 4,
  parameter int HIT_W = 2,
  parameter logic [CMD_W-1:0] DAC_CMD = 4'b1101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              framen,
  input  logic              req64n,
  input  logic [CMD_W-1:0]  cbenLow,
  input  logic              xferDone,
  input  logic              addrMatch,
  output dpStrobe_t         stb,
  output logic              devseln,
  output logic              ack64n,
  output logic [HIT_W-1:0]  barHit
);

  decState_t state;
  logic      req64Q;
  logic      devselQ;
  logic      ack64Q;
  logic      claimSet;
  logic      claimClr;

  assign stb.capFirst  = (state == ST_IDLE) && !framen;
  assign stb.capSecond = (state == ST_ADDR2);
  assign claimSet      = (state == ST_DECODE) && addrMatch;
  assign claimClr      = (state == ST_CLAIM) && framen && xferDone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      req64Q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!framen) begin
            req64Q <= !req64n;
            state  <= (cbenLow == DAC_CMD) ? ST_ADDR2 : ST_DECODE;
          end
        end
        ST_ADDR2:  state <= ST_DECODE;
        ST_DECODE: state <= addrMatch ? ST_CLAIM : ST_BUSY;
        ST_CLAIM:  if (framen && xferDone) state <= ST_IDLE;
        ST_BUSY:   if (framen) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devselQ <= 1'b0;
      ack64Q  <= 1'b0;
    end else if (claimSet) begin
      devselQ <= 1'b1;
      ack64Q  <= req64Q;
    end else if (claimClr) begin
      devselQ <= 1'b0;
      ack64Q  <= 1'b0;
    end
  end

  for (genvar g = 0; g < HIT_W; g++) begin : g_hit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        barHit[g] <= 1'b0;
      else if (claimSet) barHit[g] <= 1'b1;
      else if (claimClr) barHit[g] <= 1'b0;
    end
  end

  assign devseln = !devselQ;
  assign ack64n  = !ack64Q;

  // R5: no claim while an address phase is still being decoded
  assert_slow_decode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR2 || state == ST_DECODE) |-> devseln);

  // R6: 64-bit acknowledge only together with device select
  assert_ack_with_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack64n |-> !devseln);

  // R7: hit bits move together and track the claim
  assert_hit_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(barHit) == 0 || $countones(barHit) == HIT_W) &&
    ((barHit != '0) == !devseln));

  // R8: claim survives while the frame is still low
  assert_hold_claim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!devseln && !framen) |=> !devseln);

  // R8: release after the end condition
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!devseln && framen && xferDone) |=> (devseln && ack64n && barHit == '0));

  // R9: a miss never asserts anything
  assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && !addrMatch) |=> (devseln && ack64n));

endmodule

// File: rtl/dac_target_decode.sv
module dac_target_decode
  import dacdec_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CMD_W = 4,
  parameter int HIT_W = 2,
  parameter logic [CMD_W-1:0] DAC_CMD = 4'b1101
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                framen,
  input  logic                req64n,
  input  logic [ADDR_W-1:0]   ad,
  input  logic [2*CMD_W-1:0]  cben,
  input  logic [ADDR_W-1:0]   barBase,
  input  logic [ADDR_W-1:0]   barMask,
  input  logic                xferDone,
  output logic                devseln,
  output logic                ack64n,
  output logic [HIT_W-1:0]    barHit,
  output logic [ADDR_W-1:0]   latAddr,
  output logic [CMD_W-1:0]    latCmd
);

  dpStrobe_t stb;
  logic      addrMatch;

  dacdec_ctrl #(
    .CMD_W(CMD_W), .HIT_W(HIT_W), .DAC_CMD(DAC_CMD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .framen(framen), .req64n(req64n),
    .cbenLow(cben[CMD_W-1:0]), .xferDone(xferDone), .addrMatch(addrMatch),
    .stb(stb), .devseln(devseln), .ack64n(ack64n), .barHit(barHit)
  );

  dacdec_dpath #(
    .ADDR_W(ADDR_W), .CMD_W(CMD_W), .DAC_CMD(DAC_CMD)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .ad(ad), .cben(cben),
    .barBase(barBase), .barMask(barMask),
    .latAddr(latAddr), .latCmd(latCmd), .addrMatch(addrMatch)
  );

endmodule

// File: tb/sim_dac_target_decode.sv
`timescale 1ns/1ps
module sim_dac_target_decode;

  typedef struct packed {
    logic        dac;
    logic        req64;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [3:0]  cmd;
    logic [63:0] base;
    logic [63:0] mask;
    logic        expHit;
  } vec_t;

  localparam int NVEC = 7;
  localparam logic [63:0] MASK1M  = 64'hFFFF_FFFF_FFF0_0000;
  localparam logic [63:0] MASK16M = 64'hFFFF_FFFF_FF00_0000;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 32'h1234_5678, 32'h0000_0008, 4'h7, 64'h0000_0008_1230_0000, MASK1M, 1'b1},
    '{1'b1, 1'b0, 32'h1234_5678, 32'h0000_0008, 4'h6, 64'h0000_0008_1230_0000, MASK1M, 1'b1},
    '{1'b1, 1'b1, 32'h1234_5678, 32'h0000_0009, 4'h7, 64'h0000_0008_1230_0000, MASK1M, 1'b0},
    '{1'b0, 1'b1, 32'h8012_3456, 32'hDEAD_BEEF, 4'h6, 64'h0000_0000_8000_0000, MASK16M, 1'b1},
    '{1'b0, 1'b1, 32'h8012_3456, 32'h0000_0008, 4'h7, 64'h0000_0008_8000_0000, MASK16M, 1'b0},
    '{1'b1, 1'b1, 32'h123F_FFFC, 32'h0000_0008, 4'h7, 64'h0000_0008_1230_0000, MASK1M, 1'b1},
    '{1'b1, 1'b0, 32'h1240_0000, 32'h0000_0008, 4'h6, 64'h0000_0008_1230_0000, MASK1M, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        framen = 1'b1;
  logic        req64n = 1'b1;
  logic [63:0] ad = '0;
  logic [7:0]  cben = '0;
  logic [63:0] barBase = '0;
  logic [63:0] barMask = '0;
  logic        xferDone = 1'b0;
  logic        devseln;
  logic        ack64n;
  logic [1:0]  barHit;
  logic [63:0] latAddr;
  logic [3:0]  latCmd;

  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  dac_target_decode u0 (
    .clk(clk), .rst_n(rst_n), .framen(framen), .req64n(req64n), .ad(ad),
    .cben(cben), .barBase(barBase), .barMask(barMask), .xferDone(xferDone),
    .devseln(devseln), .ack64n(ack64n), .barHit(barHit),
    .latAddr(latAddr), .latCmd(latCmd)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runTxn(input vec_t v, input logic earlyDone);
    logic [63:0] expAddr;
    expAddr = v.dac ? {v.hi, v.lo} : {32'h0, v.lo};
    barBase = v.base;
    barMask = v.mask;
    @(negedge clk);
    framen = 1'b0;
    req64n = !v.req64;
    ad     = {v.hi, v.lo};
    cben   = v.dac ? {v.cmd, 4'b1101} : {4'hF, v.cmd};
    @(negedge clk);
    chk("R5 edge1", devseln, 1'b1);
    if (v.dac) begin
      ad   = {v.hi, v.hi};
      cben = {v.cmd, v.cmd};
      @(negedge clk);
      chk("R5 edge2", devseln, 1'b1);
      chk("R2 low half", latAddr[31:0], v.lo);
    end
    ad   = 64'hA5A5_5A5A_0F0F_F0F0;
    cben = 8'h00;
    @(negedge clk);
    chk("R5/R4 claim", devseln, !v.expHit);
    chk("R6 ack64n", ack64n, !(v.expHit && v.req64));
    chk("R7 hit", barHit, v.expHit ? 2'b11 : 2'b00);
    chk(v.dac ? "R2 addr" : "R3 addr", latAddr, expAddr);
    chk(v.dac ? "R2 cmd" : "R3 cmd", latCmd, v.cmd);
    if (earlyDone) begin
      xferDone = 1'b1;
      @(negedge clk);
      xferDone = 1'b0;
      chk("R8 hold frame low", devseln, !v.expHit);
    end
    if (!v.expHit) begin
      @(negedge clk);
      chk("R9 no claim in data phase", {devseln, ack64n, barHit}, 4'b1100);
    end
    framen = 1'b1;
    req64n = 1'b1;
    @(negedge clk);
    chk("R8 hold no done", devseln, !v.expHit);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    chk("R8 released", {devseln, ack64n, barHit}, 4'b1100);
    ad = 64'h1111_2222_3333_4444;
    @(negedge clk);
    chk("R10 addr held", latAddr, expAddr);
    chk("R10 cmd held", latCmd, v.cmd);
  endtask

  initial begin
    #(5.0 * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sel", {devseln, ack64n, barHit}, 4'b1100);
    chk("R1 reset addr", latAddr, 64'h0);
    chk("R1 reset cmd", latCmd, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) runTxn(VECS[i], 1'b0);

    // R8: end strobe while frame is still low must not release
    runTxn(VECS[0], 1'b1);

    // R9: after a miss, the next transaction is decoded normally
    runTxn(VECS[4], 1'b0);
    runTxn(VECS[3], 1'b0);

    // R1: reset during a claim
    barBase = VECS[0].base;
    barMask = VECS[0].mask;
    @(negedge clk);
    framen = 1'b0; req64n = 1'b0;
    ad = {VECS[0].hi, VECS[0].lo}; cben = {4'h7, 4'b1101};
    @(negedge clk);
    ad = {VECS[0].hi, VECS[0].hi}; cben = 8'h77;
    @(negedge clk);
    @(negedge clk);
    chk("R1 claim before reset", {devseln, ack64n, barHit}, 4'b0011);
    rst_n = 1'b0;
    #1;
    chk("R1 reset mid-claim", {devseln, ack64n, barHit}, 4'b1100);
    chk("R1 reset mid-claim addr", latAddr, 64'h0);
    framen = 1'b1; req64n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule